// File: doc/BRIEF.md
# Baud Generator with Rate Modulation

This block produces the bit-clock enable for a UART-style transmitter and receiver. Three counters run from the peripheral clock. A power-of-four prescaler comes first. A base divider follows, and its ratio is set by two mode bits. Last is a reload counter set by an 8-bit divide value N. The plain bit period is (N+1) × 4^p × (D/2) clocks, where p is the prescale select and D is 64, 32 or 16. This equals (N+1) × 2^(2p−1) × D.

An optional fractional stage can thin the raw enables. A duty value M, from 128 to 255, is added to an 8-bit phase accumulator on every raw enable. An enable is passed only when the addition carries, so M of every 256 raw enables reach the output and the dropped ones are spread evenly. The duty register is held at a legal value: writes below 80h are dropped. The register is also locked while the transmitter or receiver is enabled.

Top module: `baud_mod_gen`

## Requirements
- R1: With `mod_en` low, `bit_tick` pulses once every (N+1) × 4^p × (D/2) clocks. The first pulse comes that many clocks after reset is released.
- R2: `mode_sel` sets D as follows: 2'b00 gives D=64, 2'b01 and 2'b10 give D=32, and 2'b11 gives D=16.
- R3: `duty_rdata` reads FFh after reset.
- R4: A duty write whose value has bit 7 clear (below 80h) is ignored, and the old value stays. A write of 80h..FFh is taken on the clock edge and can be read on `duty_rdata` one cycle later.
- R5: Duty writes are ignored while `tx_en` or `rx_en` is high.
- R6: With `mod_en` high, any 256 consecutive raw periods give exactly M pulses on `bit_tick`.
- R7: The passed pulses are spread evenly. With M ≥ 80h, two passed pulses are never more than two raw periods apart. With M = 80h they are exactly two apart.
- R8: A change to `div_n`, `presc_sel` or `mode_sel` does not alter the period in progress. The new values are sampled at the next reload, and also during reset.
- R9: While `mod_en` is low the accumulator is held at zero. Each restart of modulation therefore gives the same pass/drop pattern.
- R10: `bit_tick` is high for a single clock per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | 2 | Prescale select p (divide by 4^p) |
| div_n | input | 8 | Reload divide value N |
| mode_sel | input | 2 | Base divisor select |
| mod_en | input | 1 | Rate modulation enable |
| duty_wdata | input | 8 | Duty value to write |
| duty_we | input | 1 | Duty write strobe |
| tx_en | input | 1 | Transmitter enabled (locks duty) |
| rx_en | input | 1 | Receiver enabled (locks duty) |
| duty_rdata | output | 8 | Current duty value M |
| bit_tick | output | 1 | One-cycle bit-clock enable |

## Verification
The raw enable appears in the last cycle of each period, and `bit_tick` rises one clock later. The first pulse after reset therefore comes exactly one full period after release. A duty write shows on `duty_rdata` one clock after its strobe. It affects the pass decision from the next raw enable on. A change to N or the mode bits first shows in the gap after the next pulse. The bench models these one-cycle delays behaviourally and compares both outputs at every falling edge. Window counts and pulse gaps are measured over whole sets of 256 raw periods.

// File: rtl/baud_pkg.sv
// Shared constants and helpers for the baud generator.
package baud_pkg;
    localparam int SEL_W  = 2;
    localparam int MODE_W = 2;
    localparam int HALF_W = 6;

    // Half of the base divisor D chosen by the mode bits.
    function automatic logic [HALF_W-1:0] half_div(input logic [MODE_W-1:0] mode);
        case (mode)
            2'b00:   half_div = 6'd32;
            2'b11:   half_div = 6'd8;
            default: half_div = 6'd16;
        endcase
    endfunction
endpackage

// File: rtl/baud_prescale.sv
// Power-of-four prescaler. It produces pre_tick once every 4^sel clocks.
// Assumes reload only arrives on a cycle where pre_tick is high, so a new
// select always starts from count zero.
module baud_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             reload,
    output logic             pre_tick
);
    localparam int CNT_W = 2 * ((1 << SEL_W) - 1);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Terminal count for the captured select.
    always_comb limit = CNT_W'((32'd1 << {sel_q, 1'b0}) - 32'd1);

    assign pre_tick = (cnt == limit);

    // Capture the select in reset and at every reload.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) sel_q <= sel;
    end

    // Free-running count that wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || pre_tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == '0));
endmodule

// File: rtl/baud_divider.sv
// Base divider (D/2) followed by the N+1 reload counter. raw_tick marks the
// final cycle of each plain bit period. Mode and N are shadowed and only
// change in reset or at raw_tick.
module baud_divider #(
    parameter int DIV_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pre_tick,
    input  logic [baud_pkg::MODE_W-1:0] mode,
    input  logic [DIV_W-1:0]           div_n,
    output logic                       raw_tick
);
    import baud_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic [DIV_W-1:0]  n_q;
    logic [HALF_W-1:0] dcnt;
    logic [DIV_W-1:0]  ncnt;
    logic              base_tick;

    assign base_tick = pre_tick && (dcnt == half_div(mode_q) - 1'b1);
    assign raw_tick  = base_tick && (ncnt == n_q);

    // Shadow the divide settings so a period is never cut short.
    always_ff @(posedge clk) begin
        if (!rst_n || raw_tick) begin
            mode_q <= mode;
            n_q    <= div_n;
        end
    end

    // Base counter steps on each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n || base_tick) dcnt <= '0;
        else if (pre_tick)       dcnt <= dcnt + 1'b1;
    end

    // Reload counter steps on each base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || raw_tick) ncnt <= '0;
        else if (base_tick)     ncnt <= ncnt + 1'b1;
    end

    p_reload_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_tick |=> (n_q == $past(div_n)) && (mode_q == $past(mode)) && (ncnt == '0));
    p_mode_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_tick |=> $stable(mode_q));
endmodule

// File: rtl/baud_modulator.sv
// Fractional thinning stage. On each raw tick, duty is added to the phase
// accumulator, and the tick is passed only when that sum carries. The
// output is registered, one clock after raw.
module baud_modulator #(
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_tick,
    input  logic             mod_en,
    input  logic [MOD_W-1:0] duty,
    output logic             bit_tick
);
    logic [MOD_W-1:0] acc;
    logic [MOD_W:0]   sum;

    always_comb sum = {1'b0, acc} + {1'b0, duty};

    // Phase accumulator, cleared whenever modulation is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !mod_en) acc <= '0;
        else if (raw_tick)     acc <= sum[MOD_W-1:0];
    end

    // Registered output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_tick <= 1'b0;
        else if (mod_en) bit_tick <= raw_tick && sum[MOD_W];
        else             bit_tick <= raw_tick;
    end

    p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (acc == '0));
    p_plain_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && raw_tick) |=> bit_tick);
    p_no_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_tick |=> !bit_tick);
    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

// File: rtl/baud_mod_gen.sv
// Top of the bit-rate generator. It holds the locked duty register and
// chains the prescaler, divider and modulator. Assumes duty writes arrive as
// single-cycle strobes, synchronous to clk.
module baud_mod_gen #(
    parameter int DIV_W = 8,
    parameter int MOD_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [baud_pkg::SEL_W-1:0]  presc_sel,
    input  logic [DIV_W-1:0]            div_n,
    input  logic [baud_pkg::MODE_W-1:0] mode_sel,
    input  logic                        mod_en,
    input  logic [MOD_W-1:0]            duty_wdata,
    input  logic                        duty_we,
    input  logic                        tx_en,
    input  logic                        rx_en,
    output logic [MOD_W-1:0]            duty_rdata,
    output logic                        bit_tick
);
    import baud_pkg::*;

    logic [MOD_W-1:0] duty_q;
    logic             pre_tick;
    logic             raw_tick;
    logic             wr_ok;

    assign wr_ok      = duty_we && !tx_en && !rx_en && duty_wdata[MOD_W-1];
    assign duty_rdata = duty_q;

    // Duty register: all ones after reset, only legal unlocked writes land.
    always_ff @(posedge clk) begin
        if (!rst_n)     duty_q <= '1;
        else if (wr_ok) duty_q <= duty_wdata;
    end

    baud_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(presc_sel),
        .reload(raw_tick), .pre_tick(pre_tick)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
        .mode(mode_sel), .div_n(div_n), .raw_tick(raw_tick)
    );

    baud_modulator #(.MOD_W(MOD_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .raw_tick(raw_tick),
        .mod_en(mod_en), .duty(duty_q), .bit_tick(bit_tick)
    );

    p_duty_reset_r3: assert property (@(posedge clk)
        !rst_n |=> (duty_q == '1));
    p_duty_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q[MOD_W-1]);
    p_write_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(duty_q));
endmodule

// File: tb/baud_mod_gen_test.sv
`timescale 1ns/1ps
module baud_mod_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] presc_sel = 2'd0;
    logic [7:0] div_n = 8'd0;
    logic [1:0] mode_sel = 2'b11;
    logic       mod_en = 1'b0;
    logic [7:0] duty_wdata = 8'd0;
    logic       duty_we = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [7:0] duty_rdata;
    logic       bit_tick;

    always #2 clk = ~clk;

    baud_mod_gen uut (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .div_n(div_n),
        .mode_sel(mode_sel), .mod_en(mod_en), .duty_wdata(duty_wdata),
        .duty_we(duty_we), .tx_en(tx_en), .rx_en(rx_en),
        .duty_rdata(duty_rdata), .bit_tick(bit_tick)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string phase_req = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int calc_per(input int n, input int s, input int md);
        int h;
        h = (md == 0) ? 32 : (md == 3) ? 8 : 16;
        return (n + 1) * (1 << (2 * s)) * h;
    endfunction

    // Behavioural reference: period counter, accumulator, duty value.
    int cnt, per, acc, m_model, s_sum;
    bit exp_tick, raw, raw_prev, started;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; per = calc_per(div_n, presc_sel, mode_sel);
            acc = 0; m_model = 255; exp_tick = 0; raw_prev = 0; started = 1;
        end else begin
            raw = (cnt == per - 1);
            if (raw) begin cnt = 0; per = calc_per(div_n, presc_sel, mode_sel); end
            else cnt++;
            if (!mod_en) begin acc = 0; exp_tick = raw; end
            else if (raw) begin
                s_sum = acc + m_model; exp_tick = (s_sum >= 256); acc = s_sum % 256;
            end else exp_tick = 0;
            raw_prev = raw;
            if (duty_we && !tx_en && !rx_en && duty_wdata >= 128) m_model = duty_wdata;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(bit_tick === exp_tick, phase_req, bit_tick, exp_tick);
            chk(duty_rdata === 8'(m_model), phase_req, duty_rdata, m_model);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_duty(input logic [7:0] v);
        duty_wdata = v; duty_we = 1'b1;
        @(negedge clk);
        duty_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (bit_tick) break;
        end
    endtask

    task automatic gap_to_next(output int g);
        g = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); g++;
            if (bit_tick) break;
        end
    endtask

    task automatic count_window(input int cycles, output int pulses, output int maxgap,
                                output bit dbl);
        int last, prev;
        pulses = 0; maxgap = 0; last = -1; prev = 0; dbl = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (bit_tick) begin
                pulses++;
                if (prev) dbl = 1;
                if (last >= 0 && i - last > maxgap) maxgap = i - last;
                last = i;
            end
            prev = bit_tick;
        end
    endtask

    task automatic record_pattern(output logic [15:0] pat);
        int k;
        k = 0; pat = '0;
        while (k < 16) begin
            @(negedge clk);
            if (raw_prev) begin pat[k] = bit_tick; k++; end
        end
    endtask

    initial begin
        int g, p, mg;
        bit dbl;
        logic [15:0] pa, pb;

        // R3: duty reads all ones after reset
        phase_req = "R3";
        do_reset();
        @(negedge clk);
        chk(duty_rdata == 8'hFF, "R3", duty_rdata, 255);

        // R1/R10: plain rate, minimal period 8
        phase_req = "R1";
        count_window(256 * 8, p, mg, dbl);
        chk(p == 256, "R1", p, 256);
        chk(mg == 8, "R1", mg, 8);
        chk(!dbl, "R10", dbl, 0);

        // R1: first pulse a full period after release, wider settings
        div_n = 8'd2; presc_sel = 2'd1; mode_sel = 2'b00;
        do_reset();
        gap_to_next(g);
        chk(g == calc_per(2, 1, 0), "R1", g, calc_per(2, 1, 0));
        gap_to_next(g);
        chk(g == 384, "R1", g, 384);
        div_n = 8'd5; presc_sel = 2'd2; mode_sel = 2'b01;
        do_reset();
        wait_pulse(); gap_to_next(g);
        chk(g == 1536, "R1", g, 1536);

        // R2: mode bit decoding at N=0, p=0
        phase_req = "R2";
        div_n = 8'd0; presc_sel = 2'd0;
        mode_sel = 2'b00; do_reset(); wait_pulse(); gap_to_next(g);
        chk(g == 32, "R2", g, 32);
        mode_sel = 2'b10; do_reset(); wait_pulse(); gap_to_next(g);
        chk(g == 16, "R2", g, 16);
        mode_sel = 2'b01; do_reset(); wait_pulse(); gap_to_next(g);
        chk(g == 16, "R2", g, 16);
        mode_sel = 2'b11; do_reset(); wait_pulse(); gap_to_next(g);
        chk(g == 8, "R2", g, 8);

        // R4: illegal duty values ignored, legal ones land
        phase_req = "R4";
        write_duty(8'h7F);
        chk(duty_rdata == 8'hFF, "R4", duty_rdata, 255);
        write_duty(8'h00);
        chk(duty_rdata == 8'hFF, "R4", duty_rdata, 255);
        write_duty(8'h80);
        chk(duty_rdata == 8'h80, "R4", duty_rdata, 128);

        // R5: writes locked by either enable
        phase_req = "R5";
        tx_en = 1'b1; write_duty(8'hC0);
        chk(duty_rdata == 8'h80, "R5", duty_rdata, 128);
        tx_en = 1'b0; rx_en = 1'b1; write_duty(8'hC0);
        chk(duty_rdata == 8'h80, "R5", duty_rdata, 128);
        rx_en = 1'b0; write_duty(8'hC0);
        chk(duty_rdata == 8'hC0, "R5", duty_rdata, 192);

        // R6/R7: pulse counts and spacing under modulation (period 8)
        phase_req = "R6";
        mod_en = 1'b1;
        write_duty(8'h80); repeat (5) @(negedge clk);
        count_window(256 * 8, p, mg, dbl);
        chk(p == 128, "R6", p, 128);
        chk(mg == 16, "R7", mg, 16);
        write_duty(8'hFF); repeat (3) @(negedge clk);
        count_window(256 * 8, p, mg, dbl);
        chk(p == 255, "R6", p, 255);
        chk(mg == 16, "R7", mg, 16);
        write_duty(8'hC3); repeat (7) @(negedge clk);
        count_window(256 * 8, p, mg, dbl);
        chk(p == 195, "R6", p, 195);
        chk(mg <= 16, "R7", mg, 16);
        chk(!dbl, "R10", dbl, 0);

        // R9: restart of modulation repeats the pattern
        phase_req = "R9";
        write_duty(8'hA0);
        mod_en = 1'b0; @(negedge clk); mod_en = 1'b1;
        record_pattern(pa);
        repeat (13) @(negedge clk);
        mod_en = 1'b0; @(negedge clk); mod_en = 1'b1;
        record_pattern(pb);
        chk(pa == pb, "R9", pb, pa);

        // R8: divide change applies at the next reload
        phase_req = "R8";
        mod_en = 1'b0;
        div_n = 8'd0; mode_sel = 2'b11; presc_sel = 2'd0;
        do_reset();
        wait_pulse();
        repeat (3) @(negedge clk);
        div_n = 8'd3;
        gap_to_next(g);
        chk(g == 5, "R8", g, 5);
        gap_to_next(g);
        chk(g == 32, "R8", g, 32);
        mode_sel = 2'b00;
        gap_to_next(g);
        chk(g == 32, "R8", g, 32);
        gap_to_next(g);
        chk(g == 128, "R8", g, 128);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule